// File: doc/BRIEF.md
# Multi-Mode Test Waveform Generator

This block is a synthetic sample source for exercising a high-speed data link. On every clock it produces one wide output word that carries several consecutive samples of a test waveform. The lowest sample in the word is the earliest. A two-bit selector chooses one of three shapes:

- a sawtooth that climbs by a programmable step per sample;
- a sawtooth that falls by that step per sample;
- a square wave with a programmable half period and separate levels for its high and low halves.

A one-bit phase marker follows the square wave, so an observer at the far end of the link can measure latency against a plain digital edge.

The generator runs only while its enable input is high. When enable is low, or when the selector changes, all waveform state returns to its starting point and the output word reads zero. The next word then starts a fresh waveform. Every output comes from a register, so the samples in a word reflect the inputs that were present on the clock edge that loaded it.

Top module: `test_wave_gen`

## Requirements
- R1: While `rst` is high, the next clock edge drives `sample_word` to all zeros and `phase_mark` to 0.
- R2: A clock edge with `gen_en` low loads an all-zero word and a low marker, and clears all waveform state. The first enabled word after that starts from sample value 0.
- R3: With `wave_sel` = 00, sample k of a word is the previous sample plus `step_size` modulo 2^16. Sample 0 sits in bits [15:0] and sample 1 in bits [31:16]. The sequence carries on from one word to the next.
- R4: With `wave_sel` = 01, each sample is the previous one minus `step_size` modulo 2^16, with the same lane order and continuity as R3.
- R5: With `wave_sel` = 10, the first sample after a restart is `level_hi`. Each half of the square wave lasts `half_period` samples, with 0 treated as 1. The high half outputs `level_hi` and the low half outputs `level_lo`. A phase change may fall between the two samples of a word. If `half_period` drops below the current count, the phase changes on the next sample.
- R6: `phase_mark` is 1 exactly when the word carries square-wave data and its sample 0 lies in the high half. It is 0 in every other mode.
- R7: A clock edge on which `wave_sel` differs from its value at the previous edge loads an all-zero word and a low marker, and clears all waveform state.
- R8: `wave_sel` = 11 is reserved. It loads an all-zero word and a low marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gen_en | input | 1 | Run the generator |
| wave_sel | input | 2 | 00 rising saw, 01 falling saw, 10 square, 11 reserved |
| step_size | input | 16 | Per-sample increment of the sawtooth |
| half_period | input | 16 | Samples per half of the square wave |
| level_hi | input | 16 | Sample value in the high half |
| level_lo | input | 16 | Sample value in the low half |
| sample_word | output | 32 | Two packed samples, earliest in the low bits |
| phase_mark | output | 1 | Square phase of sample 0 of the word |

## Verification
The hardest cases to reach are the square-wave corners: a phase change that falls between the two samples of one word, and a half period that is shortened while the counter already sits at or above the new value. The stimulus uses odd half periods, which move the edge into the middle of a word. It also shrinks the half period while the square wave is running and uses a half period of zero. A behavioural model counts samples one at a time and is compared with the outputs on every clock, so these cases are covered whenever they occur.

// File: rtl/test_wave_gen_pkg.sv
package test_wave_gen_pkg;

    typedef enum logic [1:0] {
        WAVE_SAW_UP = 2'b00,
        WAVE_SAW_DN = 2'b01,
        WAVE_SQUARE = 2'b10,
        WAVE_RSVD   = 2'b11
    } wave_mode_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } sq_phase_e;

    typedef struct packed {
        wave_mode_e mode_dly;
        sq_phase_e  phase;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{mode_dly: WAVE_SAW_UP, phase: PH_HIGH};

    function automatic int unsigned lanes_per_word(input int unsigned word_bytes,
                                                   input int unsigned sample_bytes);
        return word_bytes / sample_bytes;
    endfunction

    function automatic logic is_saw(input wave_mode_e m);
        return (m == WAVE_SAW_UP) || (m == WAVE_SAW_DN);
    endfunction

endpackage

// File: rtl/test_wave_ramp_lanes.sv
module test_wave_ramp_lanes #(
    parameter int SAMPLE_W = 16,
    parameter int STEP_W   = 16,
    parameter int LANES    = 2
) (
    input  logic [SAMPLE_W-1:0]       base_i,
    input  logic [STEP_W-1:0]         step_i,
    input  logic                      down_i,
    output logic [LANES*SAMPLE_W-1:0] word_o,
    output logic [SAMPLE_W-1:0]       next_base_o
);

    logic [SAMPLE_W-1:0] step_s;
    logic [SAMPLE_W-1:0] span;

    // Step applied modulo the sample width.
    generate
        if (STEP_W >= SAMPLE_W) begin : g_step_trunc
            assign step_s = step_i[SAMPLE_W-1:0];
        end else begin : g_step_ext
            assign step_s = {{(SAMPLE_W-STEP_W){1'b0}}, step_i};
        end
    endgenerate

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [SAMPLE_W-1:0] offs;
            assign offs = SAMPLE_W'(k) * step_s;
            assign word_o[k*SAMPLE_W +: SAMPLE_W] = down_i ? (base_i - offs)
                                                           : (base_i + offs);
        end
    endgenerate

    assign span        = SAMPLE_W'(LANES) * step_s;
    assign next_base_o = down_i ? (base_i - span) : (base_i + span);

endmodule

// File: rtl/test_wave_square_lanes.sv
module test_wave_square_lanes #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 16,
    parameter int LANES    = 2
) (
    input  logic [CNT_W-1:0]          cnt_i,
    input  logic                      low_i,
    input  logic [CNT_W-1:0]          period_i,
    input  logic [SAMPLE_W-1:0]       amp_hi_i,
    input  logic [SAMPLE_W-1:0]       amp_lo_i,
    output logic [LANES*SAMPLE_W-1:0] word_o,
    output logic [CNT_W-1:0]          next_cnt_o,
    output logic                      next_low_o
);

    logic [CNT_W-1:0]            eff_period;
    logic [LANES:0][CNT_W-1:0]   cnt_c;
    logic [LANES:0]              low_c;

    assign eff_period = (period_i == '0) ? CNT_W'(1) : period_i;
    assign cnt_c[0]   = cnt_i;
    assign low_c[0]   = low_i;

    // One stage per sample: emit level, advance count, flip phase on hit.
    generate
        for (genvar k = 0; k < LANES; k++) begin : g_stage
            logic [CNT_W:0] cnt_inc;
            logic           hit;
            assign cnt_inc      = {1'b0, cnt_c[k]} + (CNT_W+1)'(1);
            assign hit          = cnt_inc >= {1'b0, eff_period};
            assign word_o[k*SAMPLE_W +: SAMPLE_W] = low_c[k] ? amp_lo_i : amp_hi_i;
            assign cnt_c[k+1]   = hit ? '0 : cnt_inc[CNT_W-1:0];
            assign low_c[k+1]   = low_c[k] ^ hit;
        end
    endgenerate

    assign next_cnt_o = cnt_c[LANES];
    assign next_low_o = low_c[LANES];

endmodule

// File: rtl/test_wave_gen.sv
module test_wave_gen
    import test_wave_gen_pkg::*;
#(
    parameter int SAMPLE_BYTES = 2,
    parameter int WORD_BYTES   = 4,
    parameter int CTRL_W       = 16,
    localparam int SAMPLE_W    = SAMPLE_BYTES * 8,
    localparam int WORD_W      = WORD_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                gen_en,
    input  logic [1:0]          wave_sel,
    input  logic [CTRL_W-1:0]   step_size,
    input  logic [CTRL_W-1:0]   half_period,
    input  logic [SAMPLE_W-1:0] level_hi,
    input  logic [SAMPLE_W-1:0] level_lo,
    output logic [WORD_W-1:0]   sample_word,
    output logic                phase_mark
);

    localparam int LANES  = int'(lanes_per_word(WORD_BYTES, SAMPLE_BYTES));
    localparam int PACK_W = LANES * SAMPLE_W;

    wave_mode_e          mode_now;
    ctl_state_t          ctl_q, ctl_n;
    logic [SAMPLE_W-1:0] ramp_q, ramp_n;
    logic [CTRL_W-1:0]   cnt_q, cnt_n;
    logic [WORD_W-1:0]   word_q, word_n;
    logic                mark_q, mark_n;
    logic                restart;

    logic [PACK_W-1:0]   ramp_word;
    logic [SAMPLE_W-1:0] ramp_next;
    logic [PACK_W-1:0]   sq_word;
    logic [CTRL_W-1:0]   sq_next_cnt;
    logic                sq_next_low;

    assign mode_now = wave_mode_e'(wave_sel);

    test_wave_ramp_lanes #(
        .SAMPLE_W (SAMPLE_W),
        .STEP_W   (CTRL_W),
        .LANES    (LANES)
    ) u_ramp (
        .base_i      (ramp_q),
        .step_i      (step_size),
        .down_i      (mode_now == WAVE_SAW_DN),
        .word_o      (ramp_word),
        .next_base_o (ramp_next)
    );

    test_wave_square_lanes #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CTRL_W),
        .LANES    (LANES)
    ) u_square (
        .cnt_i      (cnt_q),
        .low_i      (ctl_q.phase == PH_LOW),
        .period_i   (half_period),
        .amp_hi_i   (level_hi),
        .amp_lo_i   (level_lo),
        .word_o     (sq_word),
        .next_cnt_o (sq_next_cnt),
        .next_low_o (sq_next_low)
    );

    assign restart = !gen_en || (mode_now != ctl_q.mode_dly) || (mode_now == WAVE_RSVD);

    always_comb begin
        word_n         = '0;
        mark_n         = 1'b0;
        ramp_n         = ramp_q;
        cnt_n          = cnt_q;
        ctl_n.phase    = ctl_q.phase;
        ctl_n.mode_dly = mode_now;
        if (restart) begin
            ramp_n      = '0;
            cnt_n       = '0;
            ctl_n.phase = PH_HIGH;
        end else if (is_saw(mode_now)) begin
            word_n = WORD_W'(ramp_word);
            ramp_n = ramp_next;
        end else begin
            word_n      = WORD_W'(sq_word);
            cnt_n       = sq_next_cnt;
            ctl_n.phase = sq_phase_e'(sq_next_low);
            mark_n      = (ctl_q.phase == PH_HIGH);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= CTL_RESET;
            ramp_q <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            mark_q <= 1'b0;
        end else begin
            ctl_q  <= ctl_n;
            ramp_q <= ramp_n;
            cnt_q  <= cnt_n;
            word_q <= word_n;
            mark_q <= mark_n;
        end
    end

    assign sample_word = word_q;
    assign phase_mark  = mark_q;

endmodule

// File: rtl/test_wave_gen_chk.sv
module test_wave_gen_chk #(
    parameter int SAMPLE_W = 16,
    parameter int WORD_W   = 32,
    parameter int CTRL_W   = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                gen_en,
    input logic [1:0]          wave_sel,
    input logic [CTRL_W-1:0]   step_size,
    input logic [SAMPLE_W-1:0] level_hi,
    input logic [SAMPLE_W-1:0] level_lo,
    input logic [WORD_W-1:0]   sample_word,
    input logic                phase_mark,
    input logic [1:0]          mode_dly
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sample_word == '0 && !phase_mark));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !gen_en |=> (sample_word == '0 && !phase_mark));

    generate
        if (WORD_W >= 2 * SAMPLE_W) begin : g_pair
            assert_up_step_R3: assert property (@(posedge clk) disable iff (rst)
                (gen_en && wave_sel == 2'b00 && mode_dly == 2'b00) |=>
                (sample_word[2*SAMPLE_W-1:SAMPLE_W] ==
                 sample_word[SAMPLE_W-1:0] + SAMPLE_W'($past(step_size))));

            assert_down_step_R4: assert property (@(posedge clk) disable iff (rst)
                (gen_en && wave_sel == 2'b01 && mode_dly == 2'b01) |=>
                (sample_word[2*SAMPLE_W-1:SAMPLE_W] ==
                 sample_word[SAMPLE_W-1:0] - SAMPLE_W'($past(step_size))));
        end
    endgenerate

    assert_square_level_R5: assert property (@(posedge clk) disable iff (rst)
        (gen_en && wave_sel == 2'b10 && mode_dly == 2'b10) |=>
        (sample_word[SAMPLE_W-1:0] == (phase_mark ? $past(level_hi) : $past(level_lo))));

    assert_mark_square_only_R6: assert property (@(posedge clk) disable iff (rst)
        (!gen_en || wave_sel != 2'b10) |=> !phase_mark);

    assert_switch_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (wave_sel != mode_dly) |=> (sample_word == '0 && !phase_mark));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (wave_sel == 2'b11) |=> (sample_word == '0 && !phase_mark));

endmodule

bind test_wave_gen test_wave_gen_chk #(
    .SAMPLE_W (SAMPLE_W),
    .WORD_W   (WORD_W),
    .CTRL_W   (CTRL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gen_en      (gen_en),
    .wave_sel    (wave_sel),
    .step_size   (step_size),
    .level_hi    (level_hi),
    .level_lo    (level_lo),
    .sample_word (sample_word),
    .phase_mark  (phase_mark),
    .mode_dly    (ctl_q.mode_dly)
);

// File: tb/test_wave_gen_tb.sv
`timescale 1ns/1ps
module test_wave_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        gen_en;
    logic [1:0]  wave_sel;
    logic [15:0] step_size;
    logic [15:0] half_period;
    logic [15:0] level_hi;
    logic [15:0] level_lo;
    logic [31:0] sample_word;
    logic        phase_mark;

    always #2 clk = ~clk;

    test_wave_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .gen_en      (gen_en),
        .wave_sel    (wave_sel),
        .step_size   (step_size),
        .half_period (half_period),
        .level_hi    (level_hi),
        .level_lo    (level_lo),
        .sample_word (sample_word),
        .phase_mark  (phase_mark)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;
    bit started  = 0;

    // Behavioural reference state
    logic [15:0] m_ramp;
    int          m_cnt;
    bit          m_low;
    logic [1:0]  m_prev_sel;
    logic [31:0] exp_word;
    bit          exp_mark;
    string       word_tag;
    string       mark_tag;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_ramp = '0; m_cnt = 0; m_low = 0; m_prev_sel = 2'b00;
            exp_word = '0; exp_mark = 0;
            word_tag = "R1"; mark_tag = "R1";
        end else begin
            exp_word = '0;
            exp_mark = 0;
            mark_tag = "R6";
            if (!gen_en) begin
                word_tag = "R2"; mark_tag = "R2";
                m_ramp = '0; m_cnt = 0; m_low = 0;
            end else if (wave_sel != m_prev_sel) begin
                word_tag = "R7"; mark_tag = "R7";
                m_ramp = '0; m_cnt = 0; m_low = 0;
            end else if (wave_sel == 2'b11) begin
                word_tag = "R8"; mark_tag = "R8";
            end else if (wave_sel == 2'b10) begin
                word_tag = "R5";
                exp_mark = !m_low;
                for (int s = 0; s < 2; s++) begin
                    int lim;
                    lim = (half_period == 0) ? 1 : int'(half_period);
                    exp_word[s*16 +: 16] = m_low ? level_lo : level_hi;
                    m_cnt = m_cnt + 1;
                    if (m_cnt >= lim) begin
                        m_cnt = 0;
                        m_low = !m_low;
                    end
                end
            end else begin
                word_tag = (wave_sel == 2'b00) ? "R3" : "R4";
                for (int s = 0; s < 2; s++) begin
                    exp_word[s*16 +: 16] = m_ramp;
                    if (wave_sel == 2'b00) m_ramp = m_ramp + step_size;
                    else                   m_ramp = m_ramp - step_size;
                end
            end
            m_prev_sel = wave_sel;
        end
    end

    always @(negedge clk) begin
        if (started && !reported) begin
            n_checks++;
            if (sample_word !== exp_word) begin
                n_fail++;
                $display("FAIL %s word: actual %h expected %h", word_tag, sample_word, exp_word);
            end
            n_checks++;
            if (phase_mark !== exp_mark) begin
                n_fail++;
                $display("FAIL %s mark: actual %0b expected %0b", mark_tag, phase_mark, exp_mark);
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic run(input bit en, input logic [1:0] sel, input logic [15:0] stp,
                       input logic [15:0] per, input int cycles);
        gen_en = en; wave_sel = sel; step_size = stp; half_period = per;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1; gen_en = 0; wave_sel = 0; step_size = 0; half_period = 0;
        level_hi = 16'h1234; level_lo = 16'hFEDC;
        repeat (3) @(negedge clk);                 // R1 reset state checked
        rst = 0;
        run(0, 2'b00, 16'd3, 16'd0, 3);            // R2 idle
        run(1, 2'b00, 16'd3, 16'd0, 8);            // R3 rising saw
        run(1, 2'b00, 16'h7001, 16'd0, 6);         // R3 wrap
        run(1, 2'b01, 16'd5, 16'd0, 8);            // R7 switch then R4
        run(1, 2'b10, 16'd0, 16'd3, 12);           // R5 R6 odd half period
        run(1, 2'b10, 16'd0, 16'd1, 6);            // R5 toggle every sample
        run(1, 2'b10, 16'd0, 16'd0, 4);            // R5 zero as one
        run(1, 2'b10, 16'd0, 16'd5, 9);            // R5 mid-word edge
        run(1, 2'b10, 16'd0, 16'd2, 4);            // R5 shrink below count
        run(0, 2'b10, 16'd0, 16'd2, 3);            // R2 disable
        level_hi = 16'h0F0F; level_lo = 16'h8001;
        run(1, 2'b10, 16'd0, 16'd4, 10);           // R2 restart, R6
        run(1, 2'b11, 16'd9, 16'd4, 5);            // R8 reserved
        run(1, 2'b00, 16'hFFFF, 16'd4, 6);         // R7 then R3 wrap down
        run(1, 2'b01, 16'h8000, 16'd4, 6);         // R4 large step
        run(0, 2'b01, 16'd1, 16'd4, 2);            // R2
        run(1, 2'b01, 16'd1, 16'd4, 5);            // R4 restart from zero
        report();
    end

endmodule